// File: doc/BRIEF.md
# Delayed Write Termination Handler

This block runs one delayed write between the two sides of a bridge. When an initiator first presents a write, the block tells it to retry. It then drives the same write onto the target bus, attempt after attempt, until the target takes the data, aborts the write, or a configurable number of attempts has run out. Each attempt ends with a termination code from the target.

When the original initiator comes back with its retry, it receives a response derived from how the target ended the write:

- **Completion:** a successful write comes back as a completion, or as a disconnect after the first data transfer when more than one data phase was asked for.
- **Abort:** an aborted write comes back as a target abort.
- **Retry limit reached:** the write is dropped and the initiator is answered with a target abort. Under a register-bit enable and disable pair, a one-cycle system-error pulse is raised.

Two sticky flags record target aborts: one seen on the target side and one signalled to the initiator. Each flag clears with its own one-cycle clear pulse. The attempt limit is 2^DEF_LOG by default and 2^MAX_LOG when a select bit is set. With default parameters these are 2^24 and 2^32.

Top module: `dwr_term_handler`

## Requirements
- R1: After reset, rspValid, tgtReq, serrPulse, rxTargetAbort and sigTargetAbort are all 0.
- R2: A reqValid cycle is answered exactly one cycle later with rspValid=1 and no response appears otherwise. A request while idle is answered with rspCode 2'b00 (retry), latches reqMulti and limitSel, and raises tgtReq. A request while attempts are in progress is also answered with 2'b00.
- R3: A target termination of 2'b00 (normal) or 2'b10 (disconnect) ends the attempts (tgtReq falls). The next request gets rspCode 2'b10 (disconnect after first transfer) if the latched reqMulti was 1, else 2'b01 (completion). After that response the block is idle again.
- R4: A termination of 2'b01 (retry) below the limit leaves tgtReq high, so the write is attempted again.
- R5: A termination of 2'b11 (abort) ends the attempts and sets rxTargetAbort. The next request gets rspCode 2'b11 (target abort), and sigTargetAbort is set when that response is given.
- R6: The attempt limit is 2^DEF_LOG when the latched limitSel is 0 and 2^MAX_LOG when it is 1. When that many consecutive attempts all end in retry, attempts stop and the write is discarded. The next request gets rspCode 2'b11 and sets sigTargetAbort, while rxTargetAbort is left unchanged.
- R7: serrPulse is high for exactly one cycle when the limit of R6 is reached, and only if serrEnable=1 and nonDeliveryDisable=0 at that time.
- R8: rxTargetAbort and sigTargetAbort hold their value until their own clear pulse (clrRxAbort, clrSigAbort). A set in the same cycle as a clear wins.
- R9: The attempt count restarts at zero for every newly accepted write, so each write gets the full limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Initiator presents (or retries) the delayed write |
| reqMulti | input | 1 | Initiator requested more than one data phase |
| rspValid | output | 1 | Response to the initiator is valid |
| rspCode | output | 2 | 00 retry, 01 completion, 10 disconnect, 11 target abort |
| tgtReq | output | 1 | Write attempt requested on the target bus |
| tgtDone | input | 1 | Target attempt finished this cycle |
| tgtTerm | input | 2 | 00 normal, 01 retry, 10 disconnect, 11 abort |
| limitSel | input | 1 | 0: limit 2^DEF_LOG, 1: limit 2^MAX_LOG |
| serrEnable | input | 1 | System-error report enable bit |
| nonDeliveryDisable | input | 1 | Suppresses the non-delivery system error |
| clrRxAbort | input | 1 | Clears rxTargetAbort |
| clrSigAbort | input | 1 | Clears sigTargetAbort |
| rxTargetAbort | output | 1 | Sticky: target aborted a write |
| sigTargetAbort | output | 1 | Sticky: target abort signalled to initiator |
| serrPulse | output | 1 | One-cycle system-error pulse |

## Verification
The bench builds the block with DEF_LOG=3 and MAX_LOG=4, which gives limits of 8 and 16 attempts. With those values, the retry-limit path, both limit selections and the restart of the count on a new write are all reached in a few dozen cycles each. The same path with the default parameters would need millions of cycles. The system-error gating is exercised under all three relevant enable/disable settings.

// File: rtl/dwt_pkg.sv
package dwt_pkg;

  typedef enum logic [1:0] {
    TERM_NORMAL = 2'b00,
    TERM_RETRY  = 2'b01,
    TERM_DISC   = 2'b10,
    TERM_ABORT  = 2'b11
  } termCode_e;

  typedef enum logic [1:0] {
    RSP_RETRY      = 2'b00,
    RSP_COMPLETE   = 2'b01,
    RSP_DISCONNECT = 2'b10,
    RSP_TABORT     = 2'b11
  } rspCode_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'b00,
    ST_ATTEMPT = 2'b01,
    ST_RESULT  = 2'b10
  } state_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic     clrCount;
    logic     incCount;
    logic     latchReq;
    logic     loadResult;
    rspCode_e resultCode;
    logic     rspFire;
    logic     rspFromResult;
    logic     setRxAbort;
    logic     setSigAbort;
    logic     fireSerr;
  } dpStrobe_t;

endpackage

// File: rtl/dwt_datapath.sv
module dwt_datapath
  import dwt_pkg::*;
#(
  parameter int DEF_LOG = 24,
  parameter int MAX_LOG = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobe_t  stb,
  input  logic       reqMulti,
  input  logic       limitSel,
  input  logic       clrRxAbort,
  input  logic       clrSigAbort,
  output logic       lastAttempt,
  output logic       multiLatched,
  output logic       resultAbort,
  output logic       rspValid,
  output logic [1:0] rspCode,
  output logic       rxTargetAbort,
  output logic       sigTargetAbort,
  output logic       serrPulse
);

  localparam int CW = MAX_LOG + 1;
  localparam logic [CW-1:0] ONE      = CW'(1);
  localparam logic [CW-1:0] DEF_MASK = (ONE << DEF_LOG) - ONE;
  localparam logic [CW-1:0] MAX_MASK = (ONE << MAX_LOG) - ONE;

  logic [CW-1:0] attemptCnt;
  logic          selLatched;
  rspCode_e      resultReg;
  logic [CW-1:0] limitMask;

  // Attempt counter and request attributes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      attemptCnt   <= '0;
      selLatched   <= 1'b0;
      multiLatched <= 1'b0;
    end else begin
      if (stb.clrCount) begin
        attemptCnt <= '0;
      end else if (stb.incCount) begin
        attemptCnt <= attemptCnt + ONE;
      end
      if (stb.latchReq) begin
        selLatched   <= limitSel;
        multiLatched <= reqMulti;
      end
    end
  end

  assign limitMask   = selLatched ? MAX_MASK : DEF_MASK;
  assign lastAttempt = (attemptCnt == limitMask);

  // Stored termination result
  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultReg <= RSP_RETRY;
    end else if (stb.loadResult) begin
      resultReg <= stb.resultCode;
    end
  end

  assign resultAbort = (resultReg == RSP_TABORT);

  // Response register toward the initiator
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspCode  <= 2'b00;
    end else begin
      rspValid <= stb.rspFire;
      if (stb.rspFire) begin
        rspCode <= stb.rspFromResult ? resultReg : RSP_RETRY;
      end
    end
  end

  // Sticky flags; a set wins over a clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxTargetAbort  <= 1'b0;
      sigTargetAbort <= 1'b0;
    end else begin
      if (stb.setRxAbort) begin
        rxTargetAbort <= 1'b1;
      end else if (clrRxAbort) begin
        rxTargetAbort <= 1'b0;
      end
      if (stb.setSigAbort) begin
        sigTargetAbort <= 1'b1;
      end else if (clrSigAbort) begin
        sigTargetAbort <= 1'b0;
      end
    end
  end

  // System-error pulse
  always_ff @(posedge clk) begin
    if (!rstN) begin
      serrPulse <= 1'b0;
    end else begin
      serrPulse <= stb.fireSerr;
    end
  end

  // R6: the count never runs past the chosen limit
  assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    attemptCnt <= limitMask + ONE);

  // R8: flags hold without a clear
  assert_rx_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    rxTargetAbort && !clrRxAbort |=> rxTargetAbort);
  assert_sig_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    sigTargetAbort && !clrSigAbort |=> sigTargetAbort);

  // R9: a fresh write starts with an empty count
  assert_count_restart_R9: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrCount |=> attemptCnt == '0);

endmodule

// File: rtl/dwt_control.sv
module dwt_control
  import dwt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       tgtDone,
  input  logic [1:0] tgtTerm,
  input  logic       lastAttempt,
  input  logic       multiLatched,
  input  logic       resultAbort,
  input  logic       serrEnable,
  input  logic       nonDeliveryDisable,
  output logic       tgtReq,
  output dpStrobe_t  stb
);

  state_e    state, stateNext;
  termCode_e term;

  assign term = termCode_e'(tgtTerm);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      state <= stateNext;
    end
  end

  always_comb begin
    stb       = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          stb.clrCount = 1'b1;
          stb.latchReq = 1'b1;
          stb.rspFire  = 1'b1;
          stateNext    = ST_ATTEMPT;
        end
      end
      ST_ATTEMPT: begin
        if (reqValid) begin
          stb.rspFire = 1'b1;
        end
        if (tgtDone) begin
          case (term)
            TERM_NORMAL, TERM_DISC: begin
              stb.loadResult = 1'b1;
              stb.resultCode = multiLatched ? RSP_DISCONNECT : RSP_COMPLETE;
              stateNext      = ST_RESULT;
            end
            TERM_ABORT: begin
              stb.loadResult = 1'b1;
              stb.resultCode = RSP_TABORT;
              stb.setRxAbort = 1'b1;
              stateNext      = ST_RESULT;
            end
            default: begin
              stb.incCount = 1'b1;
              if (lastAttempt) begin
                stb.loadResult = 1'b1;
                stb.resultCode = RSP_TABORT;
                stb.fireSerr   = serrEnable && !nonDeliveryDisable;
                stateNext      = ST_RESULT;
              end
            end
          endcase
        end
      end
      ST_RESULT: begin
        if (reqValid) begin
          stb.rspFire       = 1'b1;
          stb.rspFromResult = 1'b1;
          stb.setSigAbort   = resultAbort;
          stateNext         = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign tgtReq = (state == ST_ATTEMPT);

  // R4: an attempt in flight keeps its request
  assert_req_held_R4: assert property (@(posedge clk) disable iff (!rstN)
    tgtReq && !tgtDone |=> tgtReq);
  // R4: a retry below the limit is attempted again
  assert_retry_again_R4: assert property (@(posedge clk) disable iff (!rstN)
    tgtReq && tgtDone && tgtTerm == 2'b01 && !lastAttempt |=> tgtReq);
  // R6: reaching the limit stops the attempts
  assert_limit_stops_R6: assert property (@(posedge clk) disable iff (!rstN)
    tgtReq && tgtDone && tgtTerm == 2'b01 && lastAttempt |=> !tgtReq);
  // R3: delivery stops the attempts
  assert_delivered_stops_R3: assert property (@(posedge clk) disable iff (!rstN)
    tgtReq && tgtDone && !tgtTerm[0] |=> !tgtReq);

endmodule

// File: rtl/dwr_term_handler.sv
module dwr_term_handler
  import dwt_pkg::*;
#(
  parameter int DEF_LOG = 24,
  parameter int MAX_LOG = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqMulti,
  output logic       rspValid,
  output logic [1:0] rspCode,
  output logic       tgtReq,
  input  logic       tgtDone,
  input  logic [1:0] tgtTerm,
  input  logic       limitSel,
  input  logic       serrEnable,
  input  logic       nonDeliveryDisable,
  input  logic       clrRxAbort,
  input  logic       clrSigAbort,
  output logic       rxTargetAbort,
  output logic       sigTargetAbort,
  output logic       serrPulse
);

  dpStrobe_t stb;
  logic      lastAttempt;
  logic      multiLatched;
  logic      resultAbort;

  dwt_control uControl (
    .clk                (clk),
    .rstN               (rstN),
    .reqValid           (reqValid),
    .tgtDone            (tgtDone),
    .tgtTerm            (tgtTerm),
    .lastAttempt        (lastAttempt),
    .multiLatched       (multiLatched),
    .resultAbort        (resultAbort),
    .serrEnable         (serrEnable),
    .nonDeliveryDisable (nonDeliveryDisable),
    .tgtReq             (tgtReq),
    .stb                (stb)
  );

  dwt_datapath #(
    .DEF_LOG (DEF_LOG),
    .MAX_LOG (MAX_LOG)
  ) uDatapath (
    .clk            (clk),
    .rstN           (rstN),
    .stb            (stb),
    .reqMulti       (reqMulti),
    .limitSel       (limitSel),
    .clrRxAbort     (clrRxAbort),
    .clrSigAbort    (clrSigAbort),
    .lastAttempt    (lastAttempt),
    .multiLatched   (multiLatched),
    .resultAbort    (resultAbort),
    .rspValid       (rspValid),
    .rspCode        (rspCode),
    .rxTargetAbort  (rxTargetAbort),
    .sigTargetAbort (sigTargetAbort),
    .serrPulse      (serrPulse)
  );

  // R2: every request is answered on the next cycle, and only then
  assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  assert_rsp_needs_req_R2: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(reqValid));
  // R7: system error only when enabled and not suppressed, one cycle wide
  assert_serr_gated_R7: assert property (@(posedge clk) disable iff (!rstN)
    serrPulse |-> $past(serrEnable && !nonDeliveryDisable));
  assert_serr_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    serrPulse |=> !serrPulse);
  // R5: an abort from the target ends the attempts and records it
  assert_abort_stops_R5: assert property (@(posedge clk) disable iff (!rstN)
    tgtReq && tgtDone && tgtTerm == 2'b11 |=> !tgtReq && rxTargetAbort);

endmodule

// File: tb/tb_dwr_term_handler.sv
module tb_dwr_term_handler;

  localparam int DEF_LOG = 3;
  localparam int MAX_LOG = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic       reqMulti = 1'b0;
  logic       rspValid;
  logic [1:0] rspCode;
  logic       tgtReq;
  logic       tgtDone = 1'b0;
  logic [1:0] tgtTerm = 2'b00;
  logic       limitSel = 1'b0;
  logic       serrEnable = 1'b0;
  logic       nonDeliveryDisable = 1'b0;
  logic       clrRxAbort = 1'b0;
  logic       clrSigAbort = 1'b0;
  logic       rxTargetAbort;
  logic       sigTargetAbort;
  logic       serrPulse;

  always #4 clk = ~clk;  // 125 MHz

  dwr_term_handler #(.DEF_LOG(DEF_LOG), .MAX_LOG(MAX_LOG)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqMulti(reqMulti),
    .rspValid(rspValid), .rspCode(rspCode), .tgtReq(tgtReq),
    .tgtDone(tgtDone), .tgtTerm(tgtTerm), .limitSel(limitSel),
    .serrEnable(serrEnable), .nonDeliveryDisable(nonDeliveryDisable),
    .clrRxAbort(clrRxAbort), .clrSigAbort(clrSigAbort),
    .rxTargetAbort(rxTargetAbort), .sigTargetAbort(sigTargetAbort),
    .serrPulse(serrPulse)
  );

  int checks = 0;
  int fails = 0;
  logic [1:0] expQ[$];
  string      tagQ[$];
  int served = 0;
  int tgtRetries = 0;
  logic [1:0] tgtEnd = 2'b00;
  int serrCount = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Target model: one attempt result per request
  always @(negedge clk) begin
    if (tgtReq && !tgtDone) begin
      tgtDone <= 1'b1;
      tgtTerm <= (served < tgtRetries) ? 2'b01 : tgtEnd;
      served  <= served + 1;
    end else begin
      tgtDone <= 1'b0;
    end
  end

  // Monitor: compare responses against scoreboard, count serr pulses
  always @(negedge clk) begin
    if (rstN && serrPulse) serrCount++;
    if (rstN && rspValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R2 unexpected response", int'(rspCode), -1);
      end else begin
        logic [1:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(rspCode == e, t, int'(rspCode), int'(e));
      end
    end
  end

  task automatic sendReq(input logic multi, input logic [1:0] exp, input string tag);
    @(negedge clk);
    reqValid = 1'b1;
    reqMulti = multi;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitTarget();
    @(negedge clk);
    while (tgtReq) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic runWrite(input logic multi, input int retries, input logic [1:0] endTerm,
                          input logic [1:0] expFinal, input int expServed, input string tag);
    served = 0;
    tgtRetries = retries;
    tgtEnd = endTerm;
    serrCount = 0;
    sendReq(multi, 2'b00, {tag, " R2 first retry"});
    if (retries >= 2) sendReq(multi, 2'b00, {tag, " R2 retry while attempting"});
    waitTarget();
    check(served == expServed, {tag, " attempts R4/R6/R9"}, served, expServed);
    sendReq(multi, expFinal, {tag, " final response"});
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(rspValid == 0, "R1 rspValid", rspValid, 0);
    check(tgtReq == 0, "R1 tgtReq", tgtReq, 0);
    check(serrPulse == 0 && rxTargetAbort == 0 && sigTargetAbort == 0,
          "R1 flags", int'({serrPulse, rxTargetAbort, sigTargetAbort}), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R3: normal, single phase -> completion
    runWrite(1'b0, 0, 2'b00, 2'b01, 1, "R3 normal single");
    // R3: normal, multi phase -> disconnect
    runWrite(1'b1, 0, 2'b00, 2'b10, 1, "R3 normal multi");
    // R3/R4: retries then disconnect, multi
    runWrite(1'b1, 3, 2'b10, 2'b10, 4, "R4 retries then disconnect");
    // R3: disconnect, single
    runWrite(1'b0, 1, 2'b10, 2'b01, 2, "R3 disconnect single");
    check(rxTargetAbort == 0 && sigTargetAbort == 0, "R3 no abort flags",
          int'({rxTargetAbort, sigTargetAbort}), 0);

    // R5: target abort
    runWrite(1'b1, 2, 2'b11, 2'b11, 3, "R5 abort");
    check(rxTargetAbort == 1, "R5 rxTargetAbort", rxTargetAbort, 1);
    check(sigTargetAbort == 1, "R5 sigTargetAbort", sigTargetAbort, 1);
    repeat (5) @(negedge clk);
    check(rxTargetAbort == 1 && sigTargetAbort == 1, "R8 sticky",
          int'({rxTargetAbort, sigTargetAbort}), 3);
    clrRxAbort = 1'b1;
    @(negedge clk);
    clrRxAbort = 1'b0;
    check(rxTargetAbort == 0 && sigTargetAbort == 1, "R8 clear rx only",
          int'({rxTargetAbort, sigTargetAbort}), 1);
    clrSigAbort = 1'b1;
    @(negedge clk);
    clrSigAbort = 1'b0;
    check(sigTargetAbort == 0, "R8 clear sig", sigTargetAbort, 0);

    // R6/R7: limit 8, serr enabled
    serrEnable = 1'b1;
    nonDeliveryDisable = 1'b0;
    limitSel = 1'b0;
    runWrite(1'b0, 100000, 2'b00, 2'b11, 8, "R6 limit default");
    check(serrCount == 1, "R7 serr one pulse", serrCount, 1);
    check(rxTargetAbort == 0, "R6 rx untouched", rxTargetAbort, 0);
    check(sigTargetAbort == 1, "R6 sig set", sigTargetAbort, 1);
    clrSigAbort = 1'b1;
    @(negedge clk);
    clrSigAbort = 1'b0;

    // R9: second write gets the full limit again; R7 suppressed by disable
    nonDeliveryDisable = 1'b1;
    runWrite(1'b1, 100000, 2'b00, 2'b11, 8, "R9 limit restart");
    check(serrCount == 0, "R7 serr suppressed by disable", serrCount, 0);

    // R6: larger limit selected; R7 enable off
    nonDeliveryDisable = 1'b0;
    serrEnable = 1'b0;
    limitSel = 1'b1;
    runWrite(1'b0, 100000, 2'b00, 2'b11, 16, "R6 limit max");
    check(serrCount == 0, "R7 serr not enabled", serrCount, 0);

    // R6: limit-1 retries still delivers
    serrEnable = 1'b1;
    runWrite(1'b1, 15, 2'b00, 2'b10, 16, "R6 last attempt delivers");
    check(serrCount == 0, "R7 no serr on delivery", serrCount, 0);

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R2 all responses seen", expQ.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule